// File: doc/BRIEF.md
# Serial Transceiver-Module Configuration Master

This block sits on the host side of a two-wire configuration link to an infrared transceiver module. It drives a clock line and a transmit-data line, and watches two inputs from the module: a receive-data line and an active-low answer indicator. A client asks for one operation at a time over a valid/ready request port. The operation is a register write, a register read, a module reset, or a power-up configuration sequence. When the operation is over, the block returns a one-cycle completion pulse together with the read byte and a flag that says whether the module answered.

All link timing comes from a tick whose period is `half_div + 1` system clocks. A transmitted bit is set up on the data line while the clock is low for a fixed number of ticks, and then the clock is held high for one tick. A read tolerates a slow module in two ways. It polls the answer indicator for a bounded number of clock pulses. If no answer arrives, it spends two filler pulses in place of the data byte. The power-up operation chains a reset, three writes and a read-back into a single request.

Top module: `irx_cfg_master`

## Requirements
- R1: The first byte of every write or read is `{1'b0,req_addr} | (req_index << 1) | dir`, where dir is 1 for a write and 0 for a read. Every byte leaves bit 0 first. The data line changes only while the clock is low and holds its value for the whole high phase.
- R2: A write (`req_op` = 0) sends the first byte, then the `req_data` byte, then two pulses with data low: 18 clock pulses in total, with the clock ending low.
- R3: After a read's first byte, the block sends pulses with data low and samples `link_ack_n` as each pulse's clock falls. Polling stops at the first low sample. It lasts at most 10 pulses.
- R4: When an answer is seen (`link_ack_n` low at poll pulse k, 0-based), the next 8 pulses capture `link_rxd` at each falling clock, least significant bit first. `rd_replied` is then 1 and `rd_data` carries the byte.
- R5: When all 10 poll samples are high, the block gives 2 filler pulses with data low. It reports `rd_replied` = 0 and `rd_data` = 0.
- R6: Every read (`req_op` = 1) ends with 4 more pulses with data low. A read therefore has 8+(k+1)+8+4 pulses with an answer and 24 pulses without one.
- R7: A module reset (`req_op` = 2) gives 30 pulses with data low. The clock is low whenever the block is idle.
- R8: Power-up (`req_op` = 3, mode in `req_data`) runs in this order: a reset; writes to address 0x40 of 0x17 at index 0, the mode at index 1 and 0xFF at index 2; then a read of index 1. The completion reports that read.
- R9: Each clock high phase lasts exactly `half_div`+1 cycles. Each data-setup low phase lasts at least 2·(`half_div`+1) cycles.
- R10: `req_ready` is low and `busy` is high from acceptance until the operation ends. Requests presented during that time are ignored and start no link activity.
- R11: `done` is high for exactly one cycle, in the first cycle that `busy` is low again. `rd_data` and `rd_replied` are valid in that cycle and are cleared when the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| half_div | input | DIV_W | Tick period minus one, in system clocks |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_op | input | 2 | 0 write, 1 read, 2 module reset, 3 power-up |
| req_addr | input | ADDR_W | Device address |
| req_index | input | IDX_W | Register index |
| req_data | input | 8 | Write data, or mode value for power-up |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Read byte, zero when no answer |
| rd_replied | output | 1 | Module answered the read |
| link_clk | output | 1 | Link clock line |
| link_txd | output | 1 | Link transmit data |
| link_rxd | input | 1 | Link receive data |
| link_ack_n | input | 1 | Module answer indicator, active low |

## Verification
A wrong sequencer stage or pulse counter shows up at the link pins inside one operation. It gives an extra or missing pulse, or a wrong bit at a rising clock, and the completion pulse then reports a pulse count that differs from the expected count. A stale poll counter or a misplaced capture index shows up as a wrong `rd_data` or `rd_replied` on the very next completion. A read with an answer at the last poll pulse separates an off-by-one poll limit from a correct one. A broken prescaler changes the high-phase width on the first pulse.

// File: rtl/irx_cfg_pkg.sv
package irx_cfg_pkg;

   typedef enum logic [1:0] {
      OP_WRITE   = 2'd0,
      OP_READ    = 2'd1,
      OP_RESET   = 2'd2,
      OP_POWERUP = 2'd3
   } irx_op_e;

   typedef enum logic [3:0] {
      ST_IDLE, ST_RESET, ST_CMD, ST_WDATA, ST_WTAIL,
      ST_POLL, ST_RDATA, ST_DUMMY, ST_RTAIL
   } irx_stage_e;

   typedef enum logic [1:0] {
      PH_IDLE, PH_SETUP, PH_HIGH
   } irx_phase_e;

   typedef struct packed {
      irx_stage_e stage;
      logic       wr;
      logic [7:0] sh;
      logic [7:0] wdata;
   } irx_launch_t;

endpackage

// File: rtl/irx_tick_gen.sv
module irx_tick_gen #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   logic [DIV_W-1:0] cnt;

   assign tick = run && (cnt == div);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       cnt <= '0;
      else if (restart || !run || tick) cnt <= '0;
      else                              cnt <= cnt + DIV_W'(1);
   end
endmodule

// File: rtl/irx_pulse_gen.sv
module irx_pulse_gen
   import irx_cfg_pkg::*;
#(
   parameter int SETUP_TICKS = 2,
   localparam int SW = $clog2(SETUP_TICKS + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic go,
   input  logic bit_in,
   input  logic rx_in,
   input  logic ack_in,
   output logic idle,
   output logic run,
   output logic link_clk,
   output logic link_txd,
   output logic done,
   output logic smp_rx,
   output logic smp_ack
);
   irx_phase_e    phase;
   logic [SW-1:0] scnt;

   assign idle = (phase == PH_IDLE);
   assign run  = !idle;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase    <= PH_IDLE;
         scnt     <= '0;
         link_clk <= 1'b0;
         link_txd <= 1'b0;
         done     <= 1'b0;
         smp_rx   <= 1'b0;
         smp_ack  <= 1'b1;
      end else begin
         done <= 1'b0;
         unique case (phase)
            PH_IDLE: if (go) begin
               phase    <= PH_SETUP;
               scnt     <= '0;
               link_txd <= bit_in;
            end
            PH_SETUP: if (tick) begin
               if (scnt == SW'(SETUP_TICKS - 1)) begin
                  phase    <= PH_HIGH;
                  link_clk <= 1'b1;
               end else begin
                  scnt <= scnt + SW'(1);
               end
            end
            PH_HIGH: if (tick) begin
               phase    <= PH_IDLE;
               link_clk <= 1'b0;
               done     <= 1'b1;
               smp_rx   <= rx_in;
               smp_ack  <= ack_in;
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/irx_cfg_seq.sv
module irx_cfg_seq
   import irx_cfg_pkg::*;
#(
   parameter int ADDR_W     = 7,
   parameter int IDX_W      = 3,
   parameter int POLL_MAX   = 10,
   parameter int RST_PULSES = 30,
   parameter int PU_ADDR    = 'h40,
   localparam int CMAX0 = (RST_PULSES > POLL_MAX) ? RST_PULSES : POLL_MAX,
   localparam int CMAX  = (CMAX0 > 8) ? CMAX0 : 8,
   localparam int CW    = $clog2(CMAX + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [1:0]        req_op,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [IDX_W-1:0]  req_index,
   input  logic [7:0]        req_data,
   output logic              req_ready,
   output logic              busy,
   output logic              go,
   output logic              go_bit,
   input  logic              eng_idle,
   input  logic              eng_done,
   input  logic              smp_rx,
   input  logic              smp_ack,
   output logic              done,
   output logic [7:0]        rd_data,
   output logic              rd_replied
);
   localparam logic [ADDR_W-1:0] PU_A = ADDR_W'(PU_ADDR);

   irx_stage_e  stage, stage_d;
   logic [CW-1:0] cnt, cnt_d;
   logic [7:0]  sh, sh_d, wdata, wdata_d, mode_q, mode_d, rd_d;
   logic        is_wr, is_wr_d, pu_act, pu_act_d, rep_d, done_d, fin;
   logic [2:0]  pu_step, pu_step_d;
   irx_launch_t lnc_acc, lnc_nxt;

   function automatic irx_launch_t launch(irx_op_e op, logic [ADDR_W-1:0] a,
                                          logic [IDX_W-1:0] ix, logic [7:0] d);
      irx_launch_t l;
      l.stage = (op == OP_RESET) ? ST_RESET : ST_CMD;
      l.wr    = (op == OP_WRITE);
      l.sh    = 8'(a) | (8'(ix) << 1) | {7'd0, l.wr};
      l.wdata = d;
      return l;
   endfunction

   function automatic irx_launch_t pu_launch(logic [2:0] step, logic [7:0] mode);
      case (step)
         3'd0:    return launch(OP_RESET, PU_A, IDX_W'(0), 8'h00);
         3'd1:    return launch(OP_WRITE, PU_A, IDX_W'(0), 8'h17);
         3'd2:    return launch(OP_WRITE, PU_A, IDX_W'(1), mode);
         3'd3:    return launch(OP_WRITE, PU_A, IDX_W'(2), 8'hFF);
         default: return launch(OP_READ,  PU_A, IDX_W'(1), 8'h00);
      endcase
   endfunction

   assign req_ready = (stage == ST_IDLE);
   assign busy      = !req_ready;
   assign go        = busy && eng_idle && !eng_done;
   assign go_bit    = ((stage == ST_CMD) || (stage == ST_WDATA)) ? sh[0] : 1'b0;

   always_comb begin
      lnc_acc = (irx_op_e'(req_op) == OP_POWERUP) ? pu_launch(3'd0, req_data)
              : launch(irx_op_e'(req_op), req_addr, req_index, req_data);
      lnc_nxt = pu_launch(pu_step + 3'd1, mode_q);
   end

   always_comb begin
      stage_d = stage;  cnt_d = cnt;   sh_d = sh;     wdata_d = wdata;
      is_wr_d = is_wr;  pu_act_d = pu_act; pu_step_d = pu_step;
      mode_d  = mode_q; rd_d = rd_data;  rep_d = rd_replied;
      done_d  = 1'b0;   fin = 1'b0;
      if (stage == ST_IDLE) begin
         if (req_valid) begin
            pu_act_d  = (irx_op_e'(req_op) == OP_POWERUP);
            pu_step_d = 3'd0;
            mode_d    = req_data;
            stage_d   = lnc_acc.stage;
            sh_d      = lnc_acc.sh;
            is_wr_d   = lnc_acc.wr;
            wdata_d   = lnc_acc.wdata;
            cnt_d     = '0;
            rd_d      = 8'h00;
            rep_d     = 1'b0;
         end
      end else if (eng_done) begin
         unique case (stage)
            ST_RESET: if (cnt == CW'(RST_PULSES - 1)) fin = 1'b1;
                      else cnt_d = cnt + CW'(1);
            ST_CMD: begin
               sh_d = sh >> 1;
               if (cnt == CW'(7)) begin
                  cnt_d = '0;
                  if (is_wr) begin stage_d = ST_WDATA; sh_d = wdata; end
                  else stage_d = ST_POLL;
               end else cnt_d = cnt + CW'(1);
            end
            ST_WDATA: begin
               sh_d = sh >> 1;
               if (cnt == CW'(7)) begin stage_d = ST_WTAIL; cnt_d = '0; end
               else cnt_d = cnt + CW'(1);
            end
            ST_WTAIL: if (cnt == CW'(1)) fin = 1'b1;
                      else cnt_d = cnt + CW'(1);
            ST_POLL: begin
               if (!smp_ack) begin
                  stage_d = ST_RDATA; cnt_d = '0; rep_d = 1'b1;
               end else if (cnt == CW'(POLL_MAX - 1)) begin
                  stage_d = ST_DUMMY; cnt_d = '0;
               end else cnt_d = cnt + CW'(1);
            end
            ST_RDATA: begin
               rd_d[cnt[2:0]] = smp_rx;
               if (cnt == CW'(7)) begin stage_d = ST_RTAIL; cnt_d = '0; end
               else cnt_d = cnt + CW'(1);
            end
            ST_DUMMY: if (cnt == CW'(1)) begin stage_d = ST_RTAIL; cnt_d = '0; end
                      else cnt_d = cnt + CW'(1);
            ST_RTAIL: if (cnt == CW'(3)) fin = 1'b1;
                      else cnt_d = cnt + CW'(1);
            default: stage_d = ST_IDLE;
         endcase
         if (fin) begin
            if (pu_act && (pu_step != 3'd4)) begin
               pu_step_d = pu_step + 3'd1;
               stage_d   = lnc_nxt.stage;
               sh_d      = lnc_nxt.sh;
               is_wr_d   = lnc_nxt.wr;
               wdata_d   = lnc_nxt.wdata;
               cnt_d     = '0;
            end else begin
               stage_d  = ST_IDLE;
               pu_act_d = 1'b0;
               done_d   = 1'b1;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage <= ST_IDLE; cnt <= '0; sh <= '0; wdata <= '0; is_wr <= 1'b0;
         pu_act <= 1'b0; pu_step <= 3'd0; mode_q <= '0;
         rd_data <= '0; rd_replied <= 1'b0; done <= 1'b0;
      end else begin
         stage <= stage_d; cnt <= cnt_d; sh <= sh_d; wdata <= wdata_d;
         is_wr <= is_wr_d; pu_act <= pu_act_d; pu_step <= pu_step_d;
         mode_q <= mode_d; rd_data <= rd_d; rd_replied <= rep_d; done <= done_d;
      end
   end
endmodule

// File: rtl/irx_cfg_master.sv
module irx_cfg_master #(
   parameter int DIV_W       = 8,
   parameter int ADDR_W      = 7,
   parameter int IDX_W       = 3,
   parameter int SETUP_TICKS = 2,
   parameter int POLL_MAX    = 10,
   parameter int RST_PULSES  = 30,
   parameter int SYNC_STAGES = 2,
   parameter int PU_ADDR     = 'h40
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DIV_W-1:0]  half_div,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [1:0]        req_op,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [IDX_W-1:0]  req_index,
   input  logic [7:0]        req_data,
   output logic              busy,
   output logic              done,
   output logic [7:0]        rd_data,
   output logic              rd_replied,
   output logic              link_clk,
   output logic              link_txd,
   input  logic              link_rxd,
   input  logic              link_ack_n
);
   if (ADDR_W < 1 || ADDR_W > 8)      begin : g_bad_addr  $error("ADDR_W must be 1..8");       end
   if (IDX_W < 2 || IDX_W > 7)        begin : g_bad_idx   $error("IDX_W must be 2..7");        end
   if (SETUP_TICKS < 1)               begin : g_bad_setup $error("SETUP_TICKS must be >= 1");  end
   if (POLL_MAX < 1)                  begin : g_bad_poll  $error("POLL_MAX must be >= 1");     end
   if (RST_PULSES < 1)                begin : g_bad_rst   $error("RST_PULSES must be >= 1");   end
   if (SYNC_STAGES < 0)               begin : g_bad_sync  $error("SYNC_STAGES must be >= 0");  end
   if (PU_ADDR >= (1 << ADDR_W))      begin : g_bad_pua   $error("PU_ADDR exceeds ADDR_W");    end

   logic rx_s, ack_s;
   logic tick, eng_run, eng_idle, eng_done, smp_rx, smp_ack, go, go_bit;

   if (SYNC_STAGES == 0) begin : g_nosync
      assign rx_s  = link_rxd;
      assign ack_s = link_ack_n;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] rx_p, ack_p;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rx_p  <= '0;
            ack_p <= '1;
         end else begin
            rx_p[0]  <= link_rxd;
            ack_p[0] <= link_ack_n;
            for (int i = 1; i < SYNC_STAGES; i++) begin
               rx_p[i]  <= rx_p[i-1];
               ack_p[i] <= ack_p[i-1];
            end
         end
      end
      assign rx_s  = rx_p[SYNC_STAGES-1];
      assign ack_s = ack_p[SYNC_STAGES-1];
   end

   irx_tick_gen #(.DIV_W(DIV_W)) u_tick (
      .clk(clk), .rst_n(rst_n), .restart(go), .run(eng_run),
      .div(half_div), .tick(tick)
   );

   irx_pulse_gen #(.SETUP_TICKS(SETUP_TICKS)) u_pulse (
      .clk(clk), .rst_n(rst_n), .tick(tick), .go(go), .bit_in(go_bit),
      .rx_in(rx_s), .ack_in(ack_s), .idle(eng_idle), .run(eng_run),
      .link_clk(link_clk), .link_txd(link_txd), .done(eng_done),
      .smp_rx(smp_rx), .smp_ack(smp_ack)
   );

   irx_cfg_seq #(
      .ADDR_W(ADDR_W), .IDX_W(IDX_W), .POLL_MAX(POLL_MAX),
      .RST_PULSES(RST_PULSES), .PU_ADDR(PU_ADDR)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_addr(req_addr), .req_index(req_index), .req_data(req_data),
      .req_ready(req_ready), .busy(busy), .go(go), .go_bit(go_bit),
      .eng_idle(eng_idle), .eng_done(eng_done), .smp_rx(smp_rx),
      .smp_ack(smp_ack), .done(done), .rd_data(rd_data), .rd_replied(rd_replied)
   );
endmodule

// File: rtl/irx_cfg_checker.sv
module irx_cfg_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       req_valid,
   input logic       req_ready,
   input logic       busy,
   input logic       done,
   input logic [7:0] rd_data,
   input logic       rd_replied,
   input logic       link_clk,
   input logic       link_txd
);
   assert_txd_stable_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (link_clk && $past(link_clk)) |-> $stable(link_txd));

   assert_no_reply_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !rd_replied) |-> (rd_data == 8'h00));

   assert_idle_clk_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !link_clk);

   assert_start_by_request_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(req_valid && req_ready));

   assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_at_end_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);
endmodule

bind irx_cfg_master irx_cfg_checker u_chk (.*);

// File: tb/tb_irx_cfg_master.sv
`timescale 1ns/1ps
module tb_irx_cfg_master;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] half_div = 8'd3;
   logic       req_valid = 1'b0;
   logic [1:0] req_op = 2'd0;
   logic [6:0] req_addr = '0;
   logic [2:0] req_index = '0;
   logic [7:0] req_data = '0;
   logic       link_rxd = 1'b0;
   logic       link_ack_n = 1'b1;
   logic       req_ready, busy, done, rd_replied, link_clk, link_txd;
   logic [7:0] rd_data;

   always #2 clk = ~clk;

   irx_cfg_master dut (
      .clk(clk), .rst_n(rst_n), .half_div(half_div), .req_valid(req_valid),
      .req_ready(req_ready), .req_op(req_op), .req_addr(req_addr),
      .req_index(req_index), .req_data(req_data), .busy(busy), .done(done),
      .rd_data(rd_data), .rd_replied(rd_replied), .link_clk(link_clk),
      .link_txd(link_txd), .link_rxd(link_rxd), .link_ack_n(link_ack_n)
   );

   typedef struct {
      logic [7:0]   rd;
      logic         rep;
      int           npulse;
      logic [127:0] bits;
      string        tag;
   } exp_t;

   exp_t q[$];
   int n_checks = 0, n_fail = 0;

   // expectation builder
   logic [127:0] eb;
   int           en;
   // slave model config
   bit         sl_on = 0;
   int         sl_base = 0, sl_d = 0;
   logic [7:0] sl_byte = 0;
   // monitor state
   logic [127:0] m_bits = '0;
   int  m_cnt = 0, hi_len = 0, lo_len = 0, t_err = 0;
   logic lc_prev = 0, done_prev = 0;

   task automatic chk(input bit ok, input string tag, input string what,
                      input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   function automatic logic [7:0] cmd(logic [6:0] a, logic [2:0] ix, logic dir);
      return {1'b0, a} | ({5'd0, ix} << 1) | {7'd0, dir};
   endfunction

   task automatic add_bits(input logic [7:0] b, input int k);
      for (int i = 0; i < k; i++) begin eb[en] = b[i]; en++; end
   endtask

   task automatic add_zeros(input int k);
      for (int i = 0; i < k; i++) begin eb[en] = 1'b0; en++; end
   endtask

   task automatic add_read(input logic [6:0] a, input logic [2:0] ix, input int dly,
                           input logic [7:0] rb, inout exp_t e);
      add_bits(cmd(a, ix, 1'b0), 8);
      if (dly < 10) begin
         add_zeros(dly + 1 + 8 + 4); e.rd = rb; e.rep = 1'b1;
      end else begin
         add_zeros(10 + 2 + 4);      e.rd = 8'h00; e.rep = 1'b0;
      end
   endtask

   // driver: builds expectation, configures slave, issues request
   task automatic run_op(input logic [1:0] op, input logic [6:0] a, input logic [2:0] ix,
                         input logic [7:0] d, input int dly, input logic [7:0] rb,
                         input string tag, input bit intrude);
      exp_t e;
      int bad;
      eb = '0; en = 0; e.rd = 8'h00; e.rep = 1'b0; e.tag = tag;
      case (op)
         2'd0: begin add_bits(cmd(a, ix, 1'b1), 8); add_bits(d, 8); add_zeros(2); end
         2'd1: add_read(a, ix, dly, rb, e);
         2'd2: add_zeros(30);
         default: begin
            add_zeros(30);
            add_bits(cmd(7'h40, 3'd0, 1'b1), 8); add_bits(8'h17, 8); add_zeros(2);
            add_bits(cmd(7'h40, 3'd1, 1'b1), 8); add_bits(d, 8);     add_zeros(2);
            add_bits(cmd(7'h40, 3'd2, 1'b1), 8); add_bits(8'hFF, 8); add_zeros(2);
            add_read(7'h40, 3'd1, dly, rb, e);
         end
      endcase
      e.bits = eb; e.npulse = en;
      sl_on   = ((op == 2'd1) || (op == 2'd3)) && (dly < 10);
      sl_base = (op == 2'd3) ? 84 : 0;
      sl_d    = dly;
      sl_byte = rb;
      q.push_back(e);
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_op = op; req_addr = a; req_index = ix; req_data = d;
      @(negedge clk);
      req_valid = 1'b0;
      if (intrude) begin
         bad = 0;
         req_valid = 1'b1; req_op = 2'd1; req_addr = 7'h11; req_index = 3'd3;
         for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (req_ready || !busy) bad++;
         end
         req_valid = 1'b0;
         chk(bad == 0, "R10", "ready high or busy low during operation", bad, 0);
      end
      while (q.size() != 0) @(negedge clk);
   endtask

   // monitor + module model + scoreboard compare
   always @(negedge clk) begin
      if (rst_n) begin
         if (link_clk && !lc_prev) begin
            if (lo_len < 2 * (int'(half_div) + 1)) t_err++;
            if (m_cnt < 128) m_bits[m_cnt] = link_txd;
            hi_len = 1;
            lo_len = 0;
         end else if (link_clk) begin
            hi_len++;
         end
         if (!link_clk && lc_prev) begin
            if (hi_len != int'(half_div) + 1) t_err++;
            m_cnt++;
            lo_len = 1;
            if (sl_on) begin
               int k;
               if (m_cnt >= sl_base + 8 + sl_d) link_ack_n = 1'b0;
               k = m_cnt - (sl_base + 9 + sl_d);
               link_rxd = (k >= 0 && k < 8) ? sl_byte[k] : 1'b0;
            end
         end else if (!link_clk && busy) begin
            lo_len++;
         end
         if (done && done_prev) chk(1'b0, "R11", "done longer than one cycle", 1, 0);
         if (done) begin
            if (q.size() == 0) begin
               chk(1'b0, "R10", "completion without accepted request", 1, 0);
            end else begin
               exp_t e;
               int first_bad;
               e = q.pop_front();
               first_bad = -1;
               for (int i = 0; i < e.npulse && i < 128; i++)
                  if (m_bits[i] !== e.bits[i] && first_bad < 0) first_bad = i;
               chk(m_cnt == e.npulse, e.tag, "pulse count", m_cnt, e.npulse);
               chk(first_bad < 0, e.tag, "R1 txd stream first bad bit index", first_bad, -1);
               chk(rd_replied === e.rep, e.tag, "rd_replied", rd_replied, e.rep);
               chk(rd_data === e.rd, e.tag, "rd_data", rd_data, e.rd);
               chk(t_err == 0, "R9", "clock phase width violations", t_err, 0);
               chk(!busy && req_ready, "R11", "busy/ready at done", {busy, req_ready}, 2'b01);
            end
            m_cnt = 0; t_err = 0; lo_len = 0; m_bits = '0;
            link_ack_n = 1'b1; link_rxd = 1'b0; sl_on = 0;
         end
         lc_prev = link_clk;
         done_prev = done;
      end
   end

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL R11 watchdog expired actual=%0d expected=%0d", q.size(), 0);
      finish_run();
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready === 1'b1, "R10", "ready after reset", req_ready, 1);
      chk(busy === 1'b0, "R10", "busy after reset", busy, 0);
      chk(link_clk === 1'b0, "R7", "link_clk after reset", link_clk, 0);
      chk(done === 1'b0 && rd_data === 8'h00, "R11", "done/rd_data after reset", {done, rd_data}, 0);

      run_op(2'd0, 7'h40, 3'd5, 8'hA5, 0, 8'h00, "R2", 1'b0);   // R1 R2 write
      half_div = 8'd0;
      run_op(2'd0, 7'h2B, 3'd0, 8'h3C, 0, 8'h00, "R2", 1'b0);   // R9 fastest tick
      half_div = 8'd3;
      run_op(2'd1, 7'h40, 3'd1, 8'h00, 0, 8'h5A, "R4", 1'b0);   // R3 R4 R6 immediate answer
      run_op(2'd1, 7'h15, 3'd6, 8'h00, 9, 8'hC3, "R4", 1'b0);   // R3 answer at last poll
      run_op(2'd1, 7'h7F, 3'd7, 8'h00, 10, 8'hEE, "R5", 1'b0);  // R5 no answer
      half_div = 8'd5;
      run_op(2'd1, 7'h01, 3'd2, 8'h00, 4, 8'h81, "R6", 1'b0);   // R6 R9 slower tick
      half_div = 8'd3;
      run_op(2'd2, 7'h00, 3'd0, 8'h00, 0, 8'h00, "R7", 1'b0);   // R7 module reset
      run_op(2'd3, 7'h00, 3'd0, 8'h03, 2, 8'h03, "R8", 1'b0);   // R8 power-up
      run_op(2'd0, 7'h33, 3'd1, 8'h69, 0, 8'h00, "R10", 1'b1);  // R10 requests while busy

      repeat (80) @(negedge clk);
      chk(m_cnt == 0 && !busy, "R10", "activity after ignored request", m_cnt, 0);
      chk(q.size() == 0, "R11", "outstanding expectations", q.size(), 0);
      finish_run();
   end
endmodule